// File: doc/BRIEF.md
# ATA Channel Soft-Reset Sequencer

This block puts an ATA/IDE register channel into a known state after power-up or before the channel is handed to other logic. A one-cycle `start` pulse begins the sequence. The block first waits a settling interval, because a hardware reset may have just happened. It then reads the status register again and again until the busy flag drops.

Once the device is idle, the block sets the software-reset bit in the device-control register and holds it for a minimum time. It then clears that bit. The interrupt-disable bit stays set in both writes, so the channel never raises an interrupt while it is reset. After a second settling interval the block polls busy again. It ends with a one-cycle `done` pulse, or with a one-cycle `error` pulse if busy does not clear within the timeout.

The block drives a plain register-port master. The status register sits at command base + 7 and the device-control register at control base + 2. All intervals are given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter, so a test can run with scaled-down values.

Top module: `ata_soft_reset_seq`

## Requirements
- R1: After reset, `bus_rd`, `bus_wr`, `done` and `error` are all low.
- R2: After `start`, no bus access occurs for at least SETTLE_US×CYC_PER_US cycles. The first access is a read of address CMD_BASE+7, and every read uses that address.
- R3: The block keeps reading status while the returned bit 7 (busy) is 1. It issues no write until a read returns bit 7 = 0.
- R4: The first write after busy clears is 0x0E (bit 3 = 1, bit 2 = reset, bit 1 = interrupt disable) to address CTRL_BASE+2. Every write uses that address.
- R5: The second write is 0x0A to the same address. Its strobe comes at least HOLD_US×CYC_PER_US cycles after the strobe of the first write.
- R6: Every write has bit 1 and bit 3 set, so interrupts stay disabled throughout.
- R7: After the 0x0A write, no read occurs for at least SETTLE_US×CYC_PER_US cycles. Polling then resumes.
- R8: When a read after the release returns bit 7 = 0, `done` pulses once and `error` stays low. The number of reads in each polling phase is the number of busy reads plus one.
- R9: If busy does not clear within TIMEOUT_US×CYC_PER_US cycles of the first poll, `error` pulses once and no write is ever issued.
- R10: If busy does not clear within the timeout after the release write, `error` pulses once and `done` stays low.
- R11: A `start` that arrives while a sequence is running is ignored: exactly two writes and one ending pulse occur, and the polling count does not restart.
- R12: `bus_rd` and `bus_wr` are single-cycle pulses and are never high together.
- R13: `done` and `error` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a reset sequence while idle |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on busy timeout |
| bus_addr | output | ADDR_W | Register address of the current access |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the cycle after `bus_rd` |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |

## Verification
The hardest situations to reach from the ports are the two timeout exits. Each needs a device that stays busy long enough for the timeout to expire, and the second must stay busy only after a successful reset pulse. The bench's device model returns busy for a programmed number of reads in each phase. A very large count gives a timeout in whichever phase it is set for, and random counts exercise the normal polling. A second `start` is injected during the first settling wait to show that it has no effect on the write count, the number of reads or the ending pulse.

// File: rtl/arst_pkg.sv
package arst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_RST_ON,
        ST_RST_HOLD,
        ST_RST_OFF
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       post_rst;
        logic       done;
        logic       err;
    } seq_regs_t;

    localparam logic [7:0] DEVCTL_ASSERT  = 8'h0E;
    localparam logic [7:0] DEVCTL_RELEASE = 8'h0A;
    localparam int unsigned STATUS_OFS    = 7;
    localparam int unsigned DEVCTL_OFS    = 2;
    localparam int unsigned BUSY_BIT      = 7;

endpackage

// File: rtl/arst_timer.sv
module arst_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/arst_port.sv
module arst_port
    import arst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [7:0]        wr_val,
    output logic              rd_valid,
    output logic              stat_busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic              wr;
        logic              rd;
        logic              vld;
    } port_regs_t;

    port_regs_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.wr    = 1'b0;
        p_d.rd    = 1'b0;
        p_d.vld   = p_q.rd;
        if (rd_req) begin
            p_d.rd   = 1'b1;
            p_d.addr = STAT_ADDR;
        end else if (wr_req) begin
            p_d.wr    = 1'b1;
            p_d.addr  = CTRL_ADDR;
            p_d.wdata = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign bus_addr  = p_q.addr;
    assign bus_wdata = p_q.wdata;
    assign bus_wr    = p_q.wr;
    assign bus_rd    = p_q.rd;
    assign rd_valid  = p_q.vld;
    assign stat_busy = bus_rdata[BUSY_BIT];

    logic unused_rdata;
    assign unused_rdata = ^{bus_rdata[6:0]};

endmodule

// File: rtl/ata_soft_reset_seq.sv
module ata_soft_reset_seq
    import arst_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] CMD_BASE  = 16'h01F0,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 16'h03F4,
    parameter int unsigned CYC_PER_US = 100,
    parameter int unsigned SETTLE_US  = 2000,
    parameter int unsigned HOLD_US    = 5,
    parameter int unsigned TIMEOUT_US = 32000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              bus_wr,
    output logic              bus_rd
);
    localparam longint unsigned SETTLE_CYC = longint'(SETTLE_US) * longint'(CYC_PER_US);
    localparam longint unsigned HOLD_CYC   = longint'(HOLD_US) * longint'(CYC_PER_US);
    localparam longint unsigned TMO_CYC    = longint'(TIMEOUT_US) * longint'(CYC_PER_US);
    localparam longint unsigned DLY_MAX    = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
    localparam int unsigned DLY_W = $clog2(DLY_MAX + 1) < 1 ? 1 : $clog2(DLY_MAX + 1);
    localparam int unsigned TMO_W = $clog2(TMO_CYC + 1) < 1 ? 1 : $clog2(TMO_CYC + 1);
    localparam logic [ADDR_W-1:0] STAT_ADDR = CMD_BASE + ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = CTRL_BASE + ADDR_W'(DEVCTL_OFS);

    seq_regs_t s_d, s_q;

    logic             dly_load, dly_exp;
    logic [DLY_W-1:0] dly_val;
    logic             tmo_load, tmo_exp;
    logic             rd_req, wr_req, rd_valid, stat_busy;
    logic [7:0]       wr_val;

    arst_timer #(.W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val), .expired(dly_exp)
    );

    arst_timer #(.W(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .load(tmo_load), .load_val(TMO_W'(TMO_CYC)), .expired(tmo_exp)
    );

    arst_port #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_port (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .wr_req(wr_req), .wr_val(wr_val),
        .rd_valid(rd_valid), .stat_busy(stat_busy),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        dly_load = 1'b0;
        dly_val  = '0;
        tmo_load = 1'b0;
        rd_req   = 1'b0;
        wr_req   = 1'b0;
        wr_val   = DEVCTL_ASSERT;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.state    = ST_SETTLE;
                    s_d.post_rst = 1'b0;
                    dly_load     = 1'b1;
                    dly_val      = DLY_W'(SETTLE_CYC);
                end
            end
            ST_SETTLE: begin
                if (dly_exp) begin
                    s_d.state = ST_RD_ISSUE;
                    tmo_load  = 1'b1;
                end
            end
            ST_RD_ISSUE: begin
                rd_req    = 1'b1;
                s_d.state = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (rd_valid) begin
                    if (!stat_busy) begin
                        if (s_q.post_rst) begin
                            s_d.done  = 1'b1;
                            s_d.state = ST_IDLE;
                        end else begin
                            s_d.state = ST_RST_ON;
                        end
                    end else if (tmo_exp) begin
                        s_d.err   = 1'b1;
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.state = ST_RD_ISSUE;
                    end
                end
            end
            ST_RST_ON: begin
                wr_req    = 1'b1;
                wr_val    = DEVCTL_ASSERT;
                dly_load  = 1'b1;
                dly_val   = DLY_W'(HOLD_CYC);
                s_d.state = ST_RST_HOLD;
            end
            ST_RST_HOLD: begin
                if (dly_exp) s_d.state = ST_RST_OFF;
            end
            ST_RST_OFF: begin
                wr_req       = 1'b1;
                wr_val       = DEVCTL_RELEASE;
                dly_load     = 1'b1;
                dly_val      = DLY_W'(SETTLE_CYC);
                s_d.post_rst = 1'b1;
                s_d.state    = ST_SETTLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, post_rst: 1'b0, done: 1'b0, err: 1'b0};
        else        s_q <= s_d;
    end

    assign done  = s_q.done;
    assign error = s_q.err;

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_wdata[1] && bus_wdata[3]));

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R12
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd);

    // R13
    done_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, error}));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr == CTRL_ADDR));

    // R2
    rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr == STAT_ADDR));

endmodule

// File: tb/ata_soft_reset_seq_test.sv
module ata_soft_reset_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CPU = 2;
    localparam int SETTLE_US = 8;
    localparam int HOLD_US = 5;
    localparam int TMO_US = 60;
    localparam int SETTLE_CYC = SETTLE_US * CPU;
    localparam int HOLD_CYC = HOLD_US * CPU;
    localparam int TMO_CYC = TMO_US * CPU;
    localparam logic [15:0] CMD_B  = 16'h0170;
    localparam logic [15:0] CTRL_B = 16'h0374;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic done, error, bus_wr, bus_rd;
    logic [15:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata = 8'h50;

    ata_soft_reset_seq #(
        .ADDR_W(16), .CMD_BASE(CMD_B), .CTRL_BASE(CTRL_B), .CYC_PER_US(CPU),
        .SETTLE_US(SETTLE_US), .HOLD_US(HOLD_US), .TIMEOUT_US(TMO_US)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0;
    int cyc = 0;
    int busy_left = 0, busy2_cfg = 0;
    bit phase2 = 0;
    int n_rd1, n_rd2, n_wr, n_done, n_err, n_bad_addr;
    int first_rd1, first_rd2, err_cyc, start_cyc;
    int wr_cyc[4];
    logic [7:0] wr_dat[4];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model and monitor, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (bus_rd) begin
                if (bus_addr != CMD_B + 16'd7) n_bad_addr++;
                if (phase2) begin
                    if (n_rd2 == 0) first_rd2 = cyc;
                    n_rd2++;
                end else begin
                    if (n_rd1 == 0) first_rd1 = cyc;
                    n_rd1++;
                end
                if (busy_left > 0) begin
                    bus_rdata = 8'hD0;
                    busy_left--;
                end else begin
                    bus_rdata = 8'h50;
                end
            end
            if (bus_wr) begin
                if (bus_addr != CTRL_B + 16'd2) n_bad_addr++;
                if (n_wr < 4) begin
                    wr_cyc[n_wr] = cyc;
                    wr_dat[n_wr] = bus_wdata;
                end
                n_wr++;
                if (bus_wdata == 8'h0A) begin
                    phase2 = 1;
                    busy_left = busy2_cfg;
                end
            end
            if (done) n_done++;
            if (error) begin
                n_err++;
                err_cyc = cyc;
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    // kind: 0 = success, 1 = timeout before reset, 2 = timeout after release
    task automatic run_case(input int b1, input int b2, input int kind, input bit inject);
        int lim;
        n_rd1 = 0; n_rd2 = 0; n_wr = 0; n_done = 0; n_err = 0; n_bad_addr = 0;
        first_rd1 = 0; first_rd2 = 0; err_cyc = 0;
        phase2 = 0; busy_left = b1; busy2_cfg = b2;
        @(posedge clk);
        #1 start = 1'b1; start_cyc = cyc;
        @(posedge clk);
        #1 start = 1'b0;
        if (inject) begin
            repeat (5) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk);
            #1 start = 1'b0;
        end
        lim = 0;
        while (n_done + n_err == 0 && lim < 5000) begin
            @(posedge clk);
            lim++;
        end
        repeat (40) @(posedge clk);
        chk(n_bad_addr == 0, "R2/R4 address", n_bad_addr, 0);
        chk(first_rd1 - start_cyc >= SETTLE_CYC, "R2 settle before first read",
            first_rd1 - start_cyc, SETTLE_CYC);
        if (kind == 1) begin
            chk(n_err == 1, "R9 error pulses", n_err, 1);
            chk(n_done == 0, "R9 no done", n_done, 0);
            chk(n_wr == 0, "R9 no write", n_wr, 0);
            chk(err_cyc - first_rd1 >= TMO_CYC, "R9 timeout length", err_cyc - first_rd1, TMO_CYC);
        end else begin
            chk(n_rd1 == b1 + 1, "R3 reads before reset", n_rd1, b1 + 1);
            chk(n_wr == 2, "R4 write count", n_wr, 2);
            chk(wr_dat[0] == 8'h0E, "R4 assert value", wr_dat[0], 8'h0E);
            chk(wr_dat[1] == 8'h0A, "R5 release value", wr_dat[1], 8'h0A);
            chk(wr_dat[0][1] && wr_dat[0][3] && wr_dat[1][1] && wr_dat[1][3],
                "R6 irq disabled", wr_dat[0] & wr_dat[1], 8'h0A);
            chk(wr_cyc[1] - wr_cyc[0] >= HOLD_CYC, "R5 hold length", wr_cyc[1] - wr_cyc[0], HOLD_CYC);
            chk(first_rd2 - wr_cyc[1] >= SETTLE_CYC, "R7 settle after release",
                first_rd2 - wr_cyc[1], SETTLE_CYC);
            if (kind == 0) begin
                chk(n_done == 1, inject ? "R11 single done" : "R8 done pulses", n_done, 1);
                chk(n_err == 0, "R8 no error", n_err, 0);
                chk(n_rd2 == b2 + 1, "R8 reads after release", n_rd2, b2 + 1);
            end else begin
                chk(n_err == 1, "R10 error pulses", n_err, 1);
                chk(n_done == 0, "R10 no done", n_done, 0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1
        chk(!bus_rd && !bus_wr, "R1 strobes in reset", {bus_rd, bus_wr}, 0);
        chk(!done && !error, "R1 pulses in reset", {done, error}, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(!bus_rd && !bus_wr && !done && !error, "R1 idle after reset",
            {bus_rd, bus_wr, done, error}, 0);
        // directed corners
        run_case(0, 0, 0, 0);
        run_case(3, 5, 0, 0);
        run_case(2, 1, 0, 1);            // R11
        run_case(100000, 0, 1, 0);       // R9
        run_case(1, 100000, 2, 0);       // R10
        run_case(0, 0, 0, 0);            // recovers after timeouts
        for (int i = 0; i < 6; i++) begin
            run_case(int'($urandom % 15), int'($urandom % 15), 0, i[0]);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule